// File: doc/BRIEF.md
# Windowed Register Access Bridge

This block gives a host on a narrow 32-bit register bus access to a 16-bit addressed internal register space. The host sees only a small window: a command word, a data word and a short direct-write range. The bridge turns host activity in that window into single-cycle requests toward the register fabric. It then waits for the fabric's acknowledge, which carries read data on reads.

There are three ways to start a fabric access. A command write with the busy bit set starts a single read or write. Data-word accesses can advance the target address by one in either direction. A write into the direct range builds a full write command from a fixed table of eight fabric addresses. All three share one busy flag. Any host write to the window while busy is set is dropped and sets a sticky error bit.

Top module: `csr_window_bridge`

## Requirements
- R1: After reset, the command word and the data word both read as zero, and no fabric request is issued.
- R2: Host offsets are: 0 for the command word, 1 for the data word, and 8 to 15 for the direct range. Command word bits are: 31 busy, 30 read (1 = read), 29 step up, 28 step down, 27 error, 19:16 byte enable, 15:0 target address. Reading the command word returns busy live and changes no state. A command write with bit 31 clear only stores the fields.
- R3: A command write with busy and read set issues one fabric read, in the next cycle, with the stored address and byte enable. When busy clears, the data word holds the acknowledged read data.
- R4: A command write with busy set and read clear issues one fabric write carrying the current data word. Busy clears on the acknowledge, and the address is not stepped.
- R5: While idle, with read clear and a step bit set, a host write to the data word stores the data and issues a fabric write. On that write's acknowledge, the address steps.
- R6: While idle, with read and a step bit set, a host read of the data word returns the current data. It also steps the address and issues a fabric read at the new address.
- R7: Address steps wrap modulo 2^16. When both step bits are set, the address steps up.
- R8: A host write to offset 8+k issues a fabric write of the host data with all byte enables set and read clear. The target is entry k of the map: 0x0010, 0x0104, 0x0400, 0x1234, 0x2000, 0x4A10, 0x8004, 0xF00C for k = 0..7. The step bits are kept, but no step follows the write.
- R9: Host writes to the command word, the data word or the direct range while busy is set have no effect other than setting the error bit. The error bit stays set until a command write with bit 27 set is made while idle.
- R10: A fabric request lasts one cycle, is issued only while busy is set, and at most one request is outstanding.
- R11: When a host write and the fabric acknowledge fall in the same cycle, the acknowledge completes normally (busy clears, the address steps where R5 applies) and the host write is rejected as in R9.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostAddr | input | 4 | Host word offset into the window |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostWdata | input | 32 | Host write data |
| hostRdata | output | 32 | Host read data (combinational for hostAddr) |
| fabReq | output | 1 | Single-cycle fabric request |
| fabAddr | output | 16 | Fabric target address |
| fabBe | output | 4 | Fabric byte enables |
| fabRead | output | 1 | 1 for a fabric read, 0 for a write |
| fabWdata | output | 32 | Fabric write data |
| fabAck | input | 1 | Fabric acknowledge |
| fabRdata | input | 32 | Fabric read data, valid with fabAck |

## Verification
A fabric acknowledge and a host write can land in the same cycle. In that cycle busy is still set, so the write must be rejected while the acknowledge still completes and steps the address. The bench provokes this case by timing a second data-word write in step-up write mode to coincide with the fabric model's acknowledge. It then checks four things: only one fabric request was seen, the address advanced once, the data word kept the first value, and the error bit is set.

// File: rtl/csr_window_pkg.sv
package csr_window_pkg;
  // command word bit positions
  localparam int CMD_BUSY_BIT = 31;
  localparam int CMD_READ_BIT = 30;
  localparam int CMD_INC_BIT  = 29;
  localparam int CMD_DEC_BIT  = 28;
  localparam int CMD_ERR_BIT  = 27;
  localparam int CMD_BE_LSB   = 16;

  // host window offsets
  localparam int CMD_OFS  = 0;
  localparam int DATA_OFS = 1;

  typedef struct packed {
    logic loadCmd;
    logic loadData;
    logic loadDirect;
    logic stepAddr;
    logic captureRd;
    logic readCmd;
    logic readData;
  } dpStrobes_t;
endpackage

// File: rtl/csr_window_ctrl.sv
module csr_window_ctrl
  import csr_window_pkg::*;
#(
  parameter int HOST_AW  = 4,
  parameter int DIRECT_N = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic               wBusy,
  input  logic               wErrClr,
  input  logic               cmdRead,
  input  logic               cmdInc,
  input  logic               cmdDec,
  input  logic               fabAck,
  output dpStrobes_t         strb,
  output logic               busy,
  output logic               errFlag,
  output logic               fabReq
);
  localparam int DIRECT_BASE = (1 << HOST_AW) - DIRECT_N;

  logic selCmd, selData, selDirect;
  logic hostTouch, reject, autoMode;
  logic launch, stepOnDone, stepNext;

  assign selCmd    = (hostAddr == HOST_AW'(CMD_OFS));
  assign selData   = (hostAddr == HOST_AW'(DATA_OFS));
  assign selDirect = (hostAddr >= HOST_AW'(DIRECT_BASE));
  assign hostTouch = hostWr & (selCmd | selData | selDirect);
  assign reject    = busy & hostTouch;
  assign autoMode  = cmdInc | cmdDec;

  always_comb begin
    strb          = '0;
    strb.readCmd  = selCmd;
    strb.readData = selData;
    launch        = 1'b0;
    stepNext      = stepOnDone;
    if (!busy) begin
      if (hostWr) begin
        if (selCmd) begin
          strb.loadCmd = 1'b1;
          if (wBusy) begin
            launch   = 1'b1;
            stepNext = 1'b0;
          end
        end else if (selData) begin
          strb.loadData = 1'b1;
          if (autoMode && !cmdRead) begin
            launch   = 1'b1;
            stepNext = 1'b1;
          end
        end else if (selDirect) begin
          strb.loadDirect = 1'b1;
          launch          = 1'b1;
          stepNext        = 1'b0;
        end
      end else if (hostRd && selData && autoMode && cmdRead) begin
        strb.stepAddr = 1'b1;
        launch        = 1'b1;
        stepNext      = 1'b0;
      end
    end else if (fabAck) begin
      strb.captureRd = cmdRead;
      strb.stepAddr  = stepOnDone;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy       <= 1'b0;
      fabReq     <= 1'b0;
      stepOnDone <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      fabReq     <= launch;
      stepOnDone <= stepNext;
      if (launch)
        busy <= 1'b1;
      else if (busy && fabAck)
        busy <= 1'b0;
      if (reject)
        errFlag <= 1'b1;
      else if (!busy && hostWr && selCmd && wErrClr)
        errFlag <= 1'b0;
    end
  end

  // R10
  req_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    fabReq |=> !fabReq);
  // R10
  req_only_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    fabReq |-> busy);
  // R9
  reject_sets_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && hostTouch) |=> errFlag);
  // R9
  err_sticky_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && busy) |=> errFlag);
  // R3
  ack_clears_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fabAck) |=> !busy);
endmodule

// File: rtl/csr_window_dp.sv
module csr_window_dp
  import csr_window_pkg::*;
#(
  parameter int HOST_AW  = 4,
  parameter int DIRECT_N = 8,
  parameter int FAB_AW   = 16,
  parameter int DW       = 32,
  parameter int BEW      = 4,
  parameter logic [DIRECT_N-1:0][FAB_AW-1:0] DIRECT_MAP = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobes_t         strb,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic [DW-1:0]      hostWdata,
  input  logic [DW-1:0]      fabRdata,
  input  logic               busy,
  input  logic               errFlag,
  output logic [DW-1:0]      hostRdata,
  output logic [FAB_AW-1:0]  fabAddr,
  output logic [BEW-1:0]     fabBe,
  output logic               fabRead,
  output logic [DW-1:0]      fabWdata,
  output logic               cmdRead,
  output logic               cmdInc,
  output logic               cmdDec
);
  localparam int DIRECT_BASE = (1 << HOST_AW) - DIRECT_N;

  logic [FAB_AW-1:0] addrReg, mapAddr;
  logic [BEW-1:0]    beReg;
  logic              readReg, incReg, decReg;
  logic [DW-1:0]     dataReg, cmdView;

  always_comb begin
    mapAddr = '0;
    for (int k = 0; k < DIRECT_N; k++)
      if (hostAddr == HOST_AW'(DIRECT_BASE + k)) mapAddr = DIRECT_MAP[k];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      beReg   <= '0;
      readReg <= 1'b0;
      incReg  <= 1'b0;
      decReg  <= 1'b0;
      dataReg <= '0;
    end else begin
      if (strb.loadCmd) begin
        addrReg <= hostWdata[FAB_AW-1:0];
        beReg   <= hostWdata[CMD_BE_LSB +: BEW];
        readReg <= hostWdata[CMD_READ_BIT];
        incReg  <= hostWdata[CMD_INC_BIT];
        decReg  <= hostWdata[CMD_DEC_BIT];
      end else if (strb.loadDirect) begin
        addrReg <= mapAddr;
        beReg   <= '1;
        readReg <= 1'b0;
      end else if (strb.stepAddr) begin
        if (incReg)      addrReg <= addrReg + FAB_AW'(1);
        else if (decReg) addrReg <= addrReg - FAB_AW'(1);
      end
      if (strb.loadData || strb.loadDirect)
        dataReg <= hostWdata;
      else if (strb.captureRd)
        dataReg <= fabRdata;
    end
  end

  always_comb begin
    cmdView                   = '0;
    cmdView[CMD_BUSY_BIT]     = busy;
    cmdView[CMD_READ_BIT]     = readReg;
    cmdView[CMD_INC_BIT]      = incReg;
    cmdView[CMD_DEC_BIT]      = decReg;
    cmdView[CMD_ERR_BIT]      = errFlag;
    cmdView[CMD_BE_LSB +: BEW] = beReg;
    cmdView[FAB_AW-1:0]       = addrReg;
  end

  assign hostRdata = strb.readCmd ? cmdView : (strb.readData ? dataReg : '0);
  assign fabAddr   = addrReg;
  assign fabBe     = beReg;
  assign fabRead   = readReg;
  assign fabWdata  = dataReg;
  assign cmdRead   = readReg;
  assign cmdInc    = incReg;
  assign cmdDec    = decReg;

  // R8
  direct_forces_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadDirect |=> (fabBe == '1) && !fabRead);
  // R9
  busy_holds_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.stepAddr) |=> $stable(fabAddr) && $stable(fabRead));
endmodule

// File: rtl/csr_window_bridge.sv
module csr_window_bridge
  import csr_window_pkg::*;
#(
  parameter int HOST_AW  = 4,
  parameter int DIRECT_N = 8,
  parameter int FAB_AW   = 16,
  parameter int DW       = 32,
  parameter int BEW      = 4,
  parameter logic [DIRECT_N-1:0][FAB_AW-1:0] DIRECT_MAP =
    {16'hF00C, 16'h8004, 16'h4A10, 16'h2000, 16'h1234, 16'h0400, 16'h0104, 16'h0010}
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [HOST_AW-1:0] hostAddr,
  input  logic               hostWr,
  input  logic               hostRd,
  input  logic [DW-1:0]      hostWdata,
  output logic [DW-1:0]      hostRdata,
  output logic               fabReq,
  output logic [FAB_AW-1:0]  fabAddr,
  output logic [BEW-1:0]     fabBe,
  output logic               fabRead,
  output logic [DW-1:0]      fabWdata,
  input  logic               fabAck,
  input  logic [DW-1:0]      fabRdata
);
  dpStrobes_t strb;
  logic busy, errFlag, cmdRead, cmdInc, cmdDec;

  csr_window_ctrl #(.HOST_AW(HOST_AW), .DIRECT_N(DIRECT_N)) ctrl_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .wBusy(hostWdata[CMD_BUSY_BIT]), .wErrClr(hostWdata[CMD_ERR_BIT]),
    .cmdRead(cmdRead), .cmdInc(cmdInc), .cmdDec(cmdDec), .fabAck(fabAck),
    .strb(strb), .busy(busy), .errFlag(errFlag), .fabReq(fabReq)
  );

  csr_window_dp #(
    .HOST_AW(HOST_AW), .DIRECT_N(DIRECT_N), .FAB_AW(FAB_AW), .DW(DW), .BEW(BEW),
    .DIRECT_MAP(DIRECT_MAP)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .fabRdata(fabRdata), .busy(busy), .errFlag(errFlag), .hostRdata(hostRdata),
    .fabAddr(fabAddr), .fabBe(fabBe), .fabRead(fabRead), .fabWdata(fabWdata),
    .cmdRead(cmdRead), .cmdInc(cmdInc), .cmdDec(cmdDec)
  );
endmodule

// File: tb/csr_window_bridge_tb.sv
`timescale 1ns/1ps
module csr_window_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  hostAddr = '0;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [31:0] hostWdata = '0, hostRdata;
  logic        fabReq, fabRead;
  logic [15:0] fabAddr;
  logic [3:0]  fabBe;
  logic [31:0] fabWdata;
  logic        fabAck = 1'b0;
  logic [31:0] fabRdata = '0;

  int nChecks = 0, nErrors = 0;
  int ackDelay = 2;
  logic [31:0] mem [int unsigned];

  typedef struct { logic [15:0] a; logic [3:0] be; logic rd; logic [31:0] d; } req_t;
  req_t expQ[$];

  always #2.5 clk = ~clk;

  csr_window_bridge dut_i (
    .clk(clk), .rstN(rstN), .hostAddr(hostAddr), .hostWr(hostWr), .hostRd(hostRd),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .fabReq(fabReq), .fabAddr(fabAddr),
    .fabBe(fabBe), .fabRead(fabRead), .fabWdata(fabWdata), .fabAck(fabAck),
    .fabRdata(fabRdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expectReq(input logic [15:0] a, input logic [3:0] be, input logic rd,
                           input logic [31:0] d);
    req_t r;
    r.a = a; r.be = be; r.rd = rd; r.d = d;
    expQ.push_back(r);
  endtask

  task automatic hostWrite(input logic [3:0] a, input logic [31:0] d);
    hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [3:0] a, output logic [31:0] d);
    hostAddr = a; hostRd = 1'b1;
    #1 d = hostRdata;
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 100; i++) begin
      hostRead(4'd0, v);
      if (!v[31]) return;
    end
    check("R10 busy never cleared", v, v & 32'h7FFF_FFFF);
  endtask

  // fabric model and scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (fabReq) begin
        req_t e;
        if (expQ.size() == 0) begin
          check("R10 unexpected fabric request", {fabRead, 11'd0, fabBe, fabAddr}, 32'hFFFF_FFFF);
        end else begin
          e = expQ.pop_front();
          check("R3/R4/R5/R6/R8 request address", {16'd0, fabAddr}, {16'd0, e.a});
          check("R3/R4/R8 request byte enable", {28'd0, fabBe}, {28'd0, e.be});
          check("R3/R4 request direction", {31'd0, fabRead}, {31'd0, e.rd});
          if (!e.rd) check("R4/R5/R8 request write data", fabWdata, e.d);
        end
        if (!fabRead) mem[fabAddr] = fabWdata;
        repeat (ackDelay) @(negedge clk);
        fabAck = 1'b1;
        fabRdata = mem.exists(fabAddr) ? mem[fabAddr] : 32'h0;
        @(negedge clk);
        fabAck = 1'b0;
        fabRdata = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 fabReq after reset", {31'd0, fabReq}, 32'd0);
    hostRead(4'd0, v); check("R1 command after reset", v, 32'h0);
    hostRead(4'd1, v); check("R1 data after reset", v, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    // R4 single write
    hostWrite(4'd1, 32'hA5A5_0001);
    expectReq(16'h0123, 4'h3, 1'b0, 32'hA5A5_0001);
    hostWrite(4'd0, 32'h8003_0123);
    hostRead(4'd0, v); check("R2 busy visible live", v, 32'h8003_0123);
    waitIdle();
    hostRead(4'd0, v); check("R4 no step after single write", v, 32'h0003_0123);

    // R3 single read
    expectReq(16'h0123, 4'hF, 1'b1, 32'h0);
    hostWrite(4'd0, 32'hC00F_0123);
    waitIdle();
    hostRead(4'd1, v); check("R3 read data captured", v, 32'hA5A5_0001);

    // R5 step-up write with R7 wrap
    hostWrite(4'd0, 32'h200F_FFFE);
    hostRead(4'd0, v); check("R2 command store without busy", v, 32'h200F_FFFE);
    for (int k = 0; k < 3; k++) begin
      expectReq(16'hFFFE + 16'(k), 4'hF, 1'b0, 32'h1000_0000 + k);
      hostWrite(4'd1, 32'h1000_0000 + k);
      waitIdle();
    end
    hostRead(4'd0, v); check("R5 R7 address stepped and wrapped", v, 32'h200F_0001);

    // R6 step-down read with R7 wrap
    expectReq(16'h0000, 4'hF, 1'b1, 32'h0);
    hostWrite(4'd0, 32'hD00F_0000);
    waitIdle();
    expectReq(16'hFFFF, 4'hF, 1'b1, 32'h0);
    hostRead(4'd1, v); check("R6 first read data", v, 32'h1000_0002);
    waitIdle();
    expectReq(16'hFFFE, 4'hF, 1'b1, 32'h0);
    hostRead(4'd1, v); check("R6 second read data", v, 32'h1000_0001);
    waitIdle();
    hostRead(4'd0, v); check("R6 R7 address after steps down", v, 32'h500F_FFFE);
    hostRead(4'd0, v); check("R2 command poll has no side effect", v, 32'h500F_FFFE);

    // R7 both step bits: up wins
    hostWrite(4'd0, 32'h300F_0200);
    expectReq(16'h0200, 4'hF, 1'b0, 32'h0000_BEEF);
    hostWrite(4'd1, 32'h0000_BEEF);
    waitIdle();
    hostRead(4'd0, v); check("R7 increment priority", v, 32'h300F_0201);

    // R8 direct range
    expectReq(16'h1234, 4'hF, 1'b0, 32'h3333_0003);
    hostWrite(4'd11, 32'h3333_0003);
    waitIdle();
    hostRead(4'd0, v); check("R8 direct index 3 command", v, 32'h300F_1234);
    expectReq(16'hF00C, 4'hF, 1'b0, 32'h7777_0007);
    hostWrite(4'd15, 32'h7777_0007);
    waitIdle();
    hostRead(4'd0, v); check("R8 direct index 7 command", v, 32'h300F_F00C);
    expectReq(16'h0010, 4'hF, 1'b0, 32'h8888_0000);
    hostWrite(4'd8, 32'h8888_0000);
    waitIdle();
    expectReq(16'h1234, 4'hF, 1'b1, 32'h0);
    hostWrite(4'd0, 32'hC00F_1234);
    waitIdle();
    hostRead(4'd1, v); check("R8 direct write landed", v, 32'h3333_0003);

    // R9 writes while busy
    ackDelay = 6;
    hostWrite(4'd0, 32'h000F_0050);
    hostWrite(4'd1, 32'h1111_2222);
    expectReq(16'h0050, 4'hF, 1'b0, 32'h1111_2222);
    hostWrite(4'd0, 32'h800F_0050);
    hostWrite(4'd1, 32'h0000_DEAD);
    hostWrite(4'd9, 32'h0000_DEAD);
    hostWrite(4'd0, 32'hC00F_0999);
    hostRead(4'd0, v); check("R9 error set, command kept", v, 32'h880F_0050);
    waitIdle();
    hostRead(4'd0, v); check("R9 error sticky", v, 32'h080F_0050);
    hostRead(4'd1, v); check("R9 data word untouched", v, 32'h1111_2222);
    hostWrite(4'd0, 32'h080F_0050);
    hostRead(4'd0, v); check("R9 error cleared", v, 32'h000F_0050);

    // R11 acknowledge and host write in the same cycle
    ackDelay = 2;
    hostWrite(4'd0, 32'h200F_0300);
    expectReq(16'h0300, 4'hF, 1'b0, 32'h5555_0001);
    hostWrite(4'd1, 32'h5555_0001);
    repeat (2) @(negedge clk);
    hostWrite(4'd1, 32'h5555_0002);
    hostRead(4'd0, v); check("R11 completion plus rejection", v, 32'h280F_0301);
    hostRead(4'd1, v); check("R11 data kept first value", v, 32'h5555_0001);

    repeat (10) @(negedge clk);
    check("R10 all expected requests seen", expQ.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule